// File: doc/BRIEF.md
# Serial Receiver with Mute and Wakeup

This block receives asynchronous serial characters on a single input line. It checks the start bit, shifts in eight data bits least significant bit first, and can check an optional parity bit. It then samples the stop bit. Each accepted character is placed in a one-deep data buffer. Four status flags report the state of the receiver: buffer full, overrun, parity error and idle line. One combined interrupt output is driven from these flags, and each flag group has its own enable.

A mute mode lets a node on a shared line ignore traffic meant for other nodes. Software can enter mute mode or leave it with two command pulses. Hardware leaves mute mode on its own in one of two ways, chosen by a wake-method bit. With the bit at 0, the receiver wakes when it detects an idle line. With the bit at 1, it wakes when it receives an address character that matches the node address. In the address wake method, hardware also enters mute mode when it receives an address character that does not match. While muted, the receiver discards data characters, but idle detection keeps running.

The framer is a state machine with five states:
- `RX_IDLE` waits for a low level on the line and then moves to `RX_START`.
- `RX_START` checks the line at half a bit time. It goes back to `RX_IDLE` if the low was a glitch, or moves on to `RX_DATA`.
- `RX_DATA` samples eight bits, one bit time apart. It then moves to `RX_PAR` when parity is enabled, or to `RX_STOP` when it is not.
- `RX_PAR` samples the parity bit and moves to `RX_STOP`.
- `RX_STOP` samples the stop bit, reports the character and returns to `RX_IDLE`.

The bit time is a parameter, given in clock cycles.

Top module: `uart_mute_rx`

## Requirements
- R1: A character is a low start bit, then 8 data bits least significant bit first, then a parity bit if `cfg_par_en`=1, then a high stop bit. Each bit lasts `BIT_CLKS` clocks. When a character is accepted, its data appears on `rd_data` and `st_full` goes to 1.
- R2: Parity is even when `cfg_par_odd`=0 and odd when it is 1. "Even" means that the data bits plus the parity bit hold an even number of ones. When parity is enabled, an accepted character whose parity does not agree sets `st_par_err`. When parity is disabled, `st_par_err` stays 0.
- R3: A one-cycle `rd_pulse` clears `st_full`, `st_ovr`, `st_par_err` and `st_idle`.
- R4: If a character is accepted while `st_full`=1, `st_ovr` goes to 1 and `rd_data` keeps the earlier data.
- R5: While `cfg_rx_en`=0 the line is ignored: no flag is set by line activity.
- R6: After a character has been received, `st_idle` goes to 1 once the line has stayed high for one full character time (10 bit times, or 11 with parity). It happens once per received character.
- R7: `mute_on_pulse` sets `st_mute` and `mute_off_pulse` clears it. A software command takes priority over a hardware change in the same cycle.
- R8: With `cfg_wake_addr`=0, an idle detection clears `st_mute`. With `cfg_wake_addr`=1, an idle detection leaves `st_mute` unchanged.
- R9: With `cfg_wake_addr`=1, an address character has data bit 7 equal to 1. If its low 4 bits equal `cfg_node_addr`, it clears `st_mute` and is accepted. If they do not, it sets `st_mute` and is not accepted.
- R10: While muted, any character that does not wake the receiver is discarded and does not set `st_full`, `st_ovr` or `st_par_err`.
- R11: `irq` is 1 when any of these hold: (`st_par_err` and `irq_par_en`), ((`st_full` or `st_ovr`) and `irq_full_en`), (`st_idle` and `irq_idle_en`).
- R12: After reset, all flags, `st_mute`, `irq` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input line, idles high |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_wake_addr | input | 1 | Wake method: 0 wakes on idle, 1 wakes on address match |
| cfg_node_addr | input | 4 | Node address compared with address characters |
| irq_par_en | input | 1 | Interrupt enable for parity error |
| irq_full_en | input | 1 | Interrupt enable for buffer full and overrun |
| irq_idle_en | input | 1 | Interrupt enable for idle line |
| mute_on_pulse | input | 1 | Software command to enter mute mode |
| mute_off_pulse | input | 1 | Software command to leave mute mode |
| rd_pulse | input | 1 | Data read strobe that clears the flags |
| rd_data | output | 8 | Buffered character |
| st_full | output | 1 | Buffer holds unread data |
| st_ovr | output | 1 | Overrun error |
| st_par_err | output | 1 | Parity error |
| st_idle | output | 1 | Idle line detected |
| st_mute | output | 1 | Receiver is in mute mode |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sends two characters with no read between them. A design that overwrote the buffer on overrun would show the second character in place of the first. A bench table sends characters with parity flipped both ways and with parity disabled, which exposes an inverted even/odd choice. Mute tests send non-address characters, a mismatched address and a matching address. A receiver that buffered muted data, or that ignored a mismatch, would show `st_full` or `st_mute` wrong. Idle tests check that the flag rises only after a full character time, fires only once, and wakes the receiver only under the idle wake method.

// File: rtl/uart_mute_rx_pkg.sv
package uart_mute_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_mute_rx_pkg::*;
#(
    parameter int BIT_CLKS = 16,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_err
);
    localparam int CW   = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam int IW   = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam int HALF = BIT_CLKS / 2;

    rx_state_e         state, state_nx;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic              par_bit;
    logic              bit_tick;
    logic              half_tick;

    assign bit_tick  = (cnt == CW'(BIT_CLKS - 1));
    assign half_tick = (cnt == CW'(HALF - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= RX_IDLE;
        else               state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (!rxd) state_nx = RX_START;
            RX_START: if (half_tick) state_nx = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_tick && idx == IW'(DATA_W - 1))
                          state_nx = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (bit_tick) state_nx = RX_STOP;
            RX_STOP:  if (bit_tick) state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    // datapath: counters and shift register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt     <= '0;
            idx     <= '0;
            data    <= '0;
            par_bit <= 1'b0;
        end else begin
            if (state != state_nx || bit_tick) cnt <= '0;
            else                               cnt <= cnt + 1'b1;
            if (state == RX_DATA && bit_tick) begin
                data <= {rxd, data[DATA_W-1:1]};
                idx  <= idx + 1'b1;
            end
            if (state == RX_START) idx <= '0;
            if (state == RX_PAR && bit_tick) par_bit <= rxd;
        end
    end

    // outputs
    always_comb begin
        busy    = (state != RX_IDLE);
        done    = (state == RX_STOP) && bit_tick;
        par_err = par_en && ((^data ^ par_bit) != par_odd);
    end
endmodule

// File: rtl/uart_idle_det.sv
module uart_idle_det #(
    parameter int BIT_CLKS = 16,
    parameter int DATA_W   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rxd,
    input  logic busy,
    input  logic par_en,
    input  logic char_done,
    output logic idle_pulse
);
    localparam int LIM_PAR = (DATA_W + 3) * BIT_CLKS;
    localparam int LIM_NOP = (DATA_W + 2) * BIT_CLKS;
    localparam int CW      = $clog2(LIM_PAR + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          armed;

    assign limit      = par_en ? CW'(LIM_PAR) : CW'(LIM_NOP);
    assign idle_pulse = armed && (cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (char_done) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (busy || !rxd || idle_pulse) begin
            cnt <= '0;
            if (idle_pulse) armed <= 1'b0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx #(
    parameter int BIT_CLKS = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              cfg_rx_en,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_wake_addr,
    input  logic [ADDR_W-1:0] cfg_node_addr,
    input  logic              irq_par_en,
    input  logic              irq_full_en,
    input  logic              irq_idle_en,
    input  logic              mute_on_pulse,
    input  logic              mute_off_pulse,
    input  logic              rd_pulse,
    output logic [DATA_W-1:0] rd_data,
    output logic              st_full,
    output logic              st_ovr,
    output logic              st_par_err,
    output logic              st_idle,
    output logic              st_mute,
    output logic              irq
);
    logic              rxd_s;
    logic              fr_busy;
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_perr;
    logic              idle_pulse;
    logic              is_addr;
    logic              addr_hit;
    logic              deliver;

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (rx_line),
        .dout(rxd_s)
    );

    uart_rx_framer #(.BIT_CLKS(BIT_CLKS), .DATA_W(DATA_W)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!cfg_rx_en),
        .rxd    (rxd_s),
        .par_en (cfg_par_en),
        .par_odd(cfg_par_odd),
        .busy   (fr_busy),
        .done   (fr_done),
        .data   (fr_data),
        .par_err(fr_perr)
    );

    uart_idle_det #(.BIT_CLKS(BIT_CLKS), .DATA_W(DATA_W)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!cfg_rx_en),
        .rxd       (rxd_s),
        .busy      (fr_busy),
        .par_en    (cfg_par_en),
        .char_done (fr_done),
        .idle_pulse(idle_pulse)
    );

    assign is_addr  = fr_data[DATA_W-1];
    assign addr_hit = (fr_data[ADDR_W-1:0] == cfg_node_addr);

    always_comb begin
        if (!fr_done || !cfg_rx_en)
            deliver = 1'b0;
        else if (st_mute)
            deliver = cfg_wake_addr && is_addr && addr_hit;
        else
            deliver = !(cfg_wake_addr && is_addr && !addr_hit);
    end

    // mute state
    always_ff @(posedge clk) begin
        if (!rst_n)                                  st_mute <= 1'b0;
        else if (mute_on_pulse)                      st_mute <= 1'b1;
        else if (mute_off_pulse)                     st_mute <= 1'b0;
        else if (fr_done && cfg_rx_en && cfg_wake_addr && is_addr)
                                                     st_mute <= !addr_hit;
        else if (idle_pulse && !cfg_wake_addr)       st_mute <= 1'b0;
    end

    // buffer and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= '0;
            st_full    <= 1'b0;
            st_ovr     <= 1'b0;
            st_par_err <= 1'b0;
            st_idle    <= 1'b0;
        end else begin
            if (rd_pulse) begin
                st_full    <= 1'b0;
                st_ovr     <= 1'b0;
                st_par_err <= 1'b0;
                st_idle    <= 1'b0;
            end
            if (idle_pulse) st_idle <= 1'b1;
            if (deliver) begin
                if (st_full && !rd_pulse) begin
                    st_ovr <= 1'b1;
                end else begin
                    rd_data    <= fr_data;
                    st_full    <= 1'b1;
                    st_par_err <= fr_perr;
                end
            end
        end
    end

    assign irq = (st_par_err && irq_par_en)
               || ((st_full || st_ovr) && irq_full_en)
               || (st_idle && irq_idle_en);
endmodule

// File: rtl/uart_mute_rx_chk.sv
module uart_mute_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_pulse,
    input logic              deliver,
    input logic              fr_done,
    input logic              idle_pulse,
    input logic              cfg_rx_en,
    input logic              mute_on_pulse,
    input logic              mute_off_pulse,
    input logic [DATA_W-1:0] rd_data,
    input logic              st_full,
    input logic              st_ovr,
    input logic              st_mute
);
    // R4
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovr) |-> $past(st_full));

    // R4
    data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && !rd_pulse) |=> $stable(rd_data));

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !deliver) |=> !st_full);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rx_en && !st_full) |=> !st_full);

    // R7
    mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mute && !mute_off_pulse && !fr_done && !idle_pulse) |=> st_mute);

    // R7
    mute_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_on_pulse |=> st_mute);
endmodule

bind uart_mute_rx uart_mute_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_pulse      (rd_pulse),
    .deliver       (deliver),
    .fr_done       (fr_done),
    .idle_pulse    (idle_pulse),
    .cfg_rx_en     (cfg_rx_en),
    .mute_on_pulse (mute_on_pulse),
    .mute_off_pulse(mute_off_pulse),
    .rd_data       (rd_data),
    .st_full       (st_full),
    .st_ovr        (st_ovr),
    .st_mute       (st_mute)
);

// File: tb/uart_mute_rx_tb.sv
module uart_mute_rx_tb;
    localparam int BIT_CLKS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       cfg_rx_en = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_wake_addr = 1'b0;
    logic [3:0] cfg_node_addr = 4'h5;
    logic       irq_par_en = 1'b0, irq_full_en = 1'b0, irq_idle_en = 1'b0;
    logic       mute_on_pulse = 1'b0, mute_off_pulse = 1'b0, rd_pulse = 1'b0;
    logic [7:0] rd_data;
    logic       st_full, st_ovr, st_par_err, st_idle, st_mute, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_mute_rx #(.BIT_CLKS(BIT_CLKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .cfg_rx_en(cfg_rx_en), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_wake_addr(cfg_wake_addr), .cfg_node_addr(cfg_node_addr),
        .irq_par_en(irq_par_en), .irq_full_en(irq_full_en), .irq_idle_en(irq_idle_en),
        .mute_on_pulse(mute_on_pulse), .mute_off_pulse(mute_off_pulse), .rd_pulse(rd_pulse),
        .rd_data(rd_data), .st_full(st_full), .st_ovr(st_ovr), .st_par_err(st_par_err),
        .st_idle(st_idle), .st_mute(st_mute), .irq(irq)
    );

    // {data[11:4], par_en[3], par_odd[2], flip[1], exp_perr[0]}
    localparam logic [11:0] VEC [8] = '{
        {8'h55, 4'b0000},
        {8'hA3, 4'b1000},
        {8'hA3, 4'b1011},
        {8'h0F, 4'b1100},
        {8'h0F, 4'b1111},
        {8'hFF, 4'b1000},
        {8'h00, 4'b1111},
        {8'h3C, 4'b0010}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic flip);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        if (cfg_par_en) begin
            rx_line = (^d) ^ cfg_par_odd ^ flip;
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_pulse = 1'b1;
        @(negedge clk);
        rd_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_mute(input logic on);
        if (on) mute_on_pulse = 1'b1; else mute_off_pulse = 1'b1;
        @(negedge clk);
        mute_on_pulse = 1'b0;
        mute_off_pulse = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check({st_full, st_ovr, st_par_err, st_idle, st_mute, irq} == 6'b0, "R12 flags",
              {st_full, st_ovr, st_par_err, st_idle, st_mute, irq}, 0);
        check(rd_data == 8'h00, "R12 data", rd_data, 0);

        // R1 R2 table walk
        for (int v = 0; v < 8; v++) begin
            cfg_par_en  = VEC[v][3];
            cfg_par_odd = VEC[v][2];
            send(VEC[v][11:4], VEC[v][1]);
            check(st_full, "R1 full", st_full, 1);
            check(rd_data == VEC[v][11:4], "R1 data", rd_data, VEC[v][11:4]);
            check(st_par_err == VEC[v][0], "R2 parity", st_par_err, VEC[v][0]);
            irq_par_en = 1'b1;
            @(negedge clk);
            check(irq == VEC[v][0], "R11 parity irq", irq, VEC[v][0]);
            irq_par_en = 1'b0;
            pulse_rd();
            check(!st_full && !st_par_err, "R3 read clears", {st_full, st_par_err}, 0);
        end
        cfg_par_en = 1'b0;
        repeat (120) @(negedge clk);
        pulse_rd();

        // R4 overrun
        send(8'h11, 1'b0);
        send(8'h22, 1'b0);
        check(st_ovr, "R4 ovr", st_ovr, 1);
        check(rd_data == 8'h11, "R4 data kept", rd_data, 8'h11);
        check(!irq, "R11 full gated", irq, 0);
        irq_full_en = 1'b1;
        @(negedge clk);
        check(irq, "R11 full irq", irq, 1);
        pulse_rd();
        check(!st_ovr && !irq, "R3 ovr cleared", {st_ovr, irq}, 0);
        irq_full_en = 1'b0;

        // R6 idle detection
        repeat (120) @(negedge clk);
        pulse_rd();
        send(8'h5A, 1'b0);
        pulse_rd();
        repeat (55) @(negedge clk);
        check(!st_idle, "R6 idle early", st_idle, 0);
        repeat (45) @(negedge clk);
        check(st_idle, "R6 idle set", st_idle, 1);
        check(!irq, "R11 idle gated", irq, 0);
        irq_idle_en = 1'b1;
        @(negedge clk);
        check(irq, "R11 idle irq", irq, 1);
        pulse_rd();
        repeat (200) @(negedge clk);
        check(!st_idle, "R6 once per char", st_idle, 0);
        irq_idle_en = 1'b0;

        // R5 disabled receiver
        cfg_rx_en = 1'b0;
        send(8'h33, 1'b0);
        repeat (120) @(negedge clk);
        check(!st_full && !st_idle, "R5 ignored", {st_full, st_idle}, 0);
        cfg_rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R7 software mute
        pulse_mute(1'b1);
        check(st_mute, "R7 set", st_mute, 1);
        pulse_mute(1'b0);
        check(!st_mute, "R7 clear", st_mute, 0);

        // R9 R10 address wake
        cfg_wake_addr = 1'b1;
        pulse_mute(1'b1);
        send(8'h12, 1'b0);
        check(!st_full && st_mute, "R10 muted data dropped", {st_full, st_mute}, 1);
        send(8'h83, 1'b0);
        check(!st_full && st_mute, "R9 mismatch stays muted", {st_full, st_mute}, 1);
        send(8'h85, 1'b0);
        check(!st_mute && st_full, "R9 match wakes", {st_mute, st_full}, 1);
        check(rd_data == 8'h85, "R9 match data", rd_data, 8'h85);
        pulse_rd();
        send(8'h8A, 1'b0);
        check(st_mute && !st_full, "R9 mismatch mutes", {st_mute, st_full}, 2);
        repeat (150) @(negedge clk);
        check(st_mute, "R8 idle no wake in addr mode", st_mute, 1);
        pulse_mute(1'b0);
        pulse_rd();

        // R8 idle wake
        cfg_wake_addr = 1'b0;
        send(8'h40, 1'b0);
        pulse_rd();
        pulse_mute(1'b1);
        check(st_mute, "R8 muted", st_mute, 1);
        repeat (120) @(negedge clk);
        check(!st_mute, "R8 idle wakes", st_mute, 0);
        check(st_idle, "R8 idle flag", st_idle, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule